// File: doc/BRIEF.md
# Display Power Management State Detector

This block watches the horizontal and vertical sync lines of a display input. For each line it decides whether pulses are arriving. From the two results it drives three active-high power-level outputs that tell the display to be fully on, in stand-by, in suspend or off. A tick prescaler divides the system clock down to a slow time base. The activity window and both state-change delays are counted in ticks of that time base.

Going into a saving state is slow on purpose. When the sync condition leaves ON, the outputs stay at the ON code until the saving condition has held for a long delay (about 5.9 s in a real system). A brief resolution change therefore does not blank the screen. Going back to ON needs a shorter, continuous run of pulses on both lines (about 0.368 s). A move from one saving state to another takes effect at once. A manual power-on input forces the ON code while it is held.

Top module: `dpm_state_detector`

## Requirements
- R1: After reset, all three outputs are 1, the shown mode is ON, and both delay counters are cleared.
- R2: Each sync line passes through a synchroniser. The line counts as active while fewer than ACT_WIN_TICKS ticks have passed since its last edge, rising or falling. After reset, both lines count as inactive.
- R3: The outputs {lvl_stby_n, lvl_susp_n, lvl_off_n} are 1,1,1 for ON (both lines active). They are 0,1,1 for stand-by (horizontal inactive, vertical active), 0,0,1 for suspend (horizontal active, vertical inactive) and 0,0,0 for off (both inactive).
- R4: While the shown mode is ON and the sync condition is a saving one, the shown mode changes to that saving condition only on the ENTRY_TICKS-th consecutive tick of that condition.
- R5: If the sync condition returns to ON before the entry delay ends, the entry count is cleared. A later departure from ON starts the count again from zero.
- R6: From a saving mode, the shown mode returns to ON only after the sync condition has been ON for EXIT_TICKS consecutive ticks. Any saving condition during that time clears the exit count.
- R7: While the shown mode is a saving one, a change of the sync condition to a different saving state updates the shown mode on the next clock, with no delay.
- R8: While force_on is 1, all three outputs are 1 in the same cycle. The internal mode keeps tracking the sync lines, so releasing force_on shows the tracked mode at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, either polarity |
| vsync_in | input | 1 | Vertical sync, asynchronous, either polarity |
| force_on | input | 1 | Manual power-on override, active high |
| lvl_stby_n | output | 1 | Low in stand-by, suspend and off |
| lvl_susp_n | output | 1 | Low in suspend and off |
| lvl_off_n | output | 1 | Low only in off |

## Verification
The hardest situation to bring about is a departure from ON that is cancelled and then repeated. A design that fails to clear the entry count only shows a fault if the two partial delays add up to more than the full delay, while neither one reaches it alone. The stimulus gates the horizontal pulse generator off, on and off again for chosen lengths. A behavioural reference model tracks the exact tick phase and synchroniser latency on every clock. The direct moves between saving states are reached by dropping one sync line at a time after stand-by has already been entered.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

   typedef enum logic [1:0] {
      PM_ON   = 2'd0,
      PM_STBY = 2'd1,
      PM_SUSP = 2'd2,
      PM_OFF  = 2'd3
   } pm_mode_e;

   // Map the two activity flags to a sync condition.
   function automatic pm_mode_e pm_classify(input logic h_act, input logic v_act);
      pm_mode_e m;
      case ({h_act, v_act})
         2'b11:   m = PM_ON;
         2'b01:   m = PM_STBY;
         2'b10:   m = PM_SUSP;
         default: m = PM_OFF;
      endcase
      return m;
   endfunction

   // Thermometer code {stby_n, susp_n, off_n}.
   function automatic logic [2:0] pm_encode(input pm_mode_e m);
      logic [2:0] c;
      case (m)
         PM_ON:   c = 3'b111;
         PM_STBY: c = 3'b011;
         PM_SUSP: c = 3'b001;
         default: c = 3'b000;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/dpm_tick_gen.sv
module dpm_tick_gen #(
   parameter int unsigned DIV = 27000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("dpm_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every_clock
         assign tick = 1'b1;
      end else begin : g_divider
         logic [CW-1:0] cnt_q;
         assign tick = (cnt_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dpm_sync_activity.sv
module dpm_sync_activity #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned ACT_WIN_TICKS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw_in,
   output logic active
);
   localparam int unsigned AW = $clog2(ACT_WIN_TICKS + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   edge_seen;
   logic [AW-1:0]          age_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("dpm_sync_activity: SYNC_STAGES must be at least 2");
      end
      if (ACT_WIN_TICKS < 1) begin : g_bad_win
         $error("dpm_sync_activity: ACT_WIN_TICKS must be at least 1");
      end

      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= raw_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;

   // Ticks since the last edge, saturating at the window length.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= AW'(ACT_WIN_TICKS);
      else if (edge_seen)
         age_q <= '0;
      else if (tick && (age_q < AW'(ACT_WIN_TICKS)))
         age_q <= age_q + 1'b1;
   end

   assign active = (age_q < AW'(ACT_WIN_TICKS));
endmodule

// File: rtl/dpm_mode_fsm.sv
module dpm_mode_fsm
   import dpm_pkg::*;
#(
   parameter int unsigned ENTRY_TICKS = 5900,
   parameter int unsigned EXIT_TICKS  = 368
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  pm_mode_e cond,
   output pm_mode_e mode
);
   localparam int unsigned EW = $clog2(ENTRY_TICKS + 1);
   localparam int unsigned XW = $clog2(EXIT_TICKS + 1);

   generate
      if (ENTRY_TICKS < 1) begin : g_bad_entry
         $error("dpm_mode_fsm: ENTRY_TICKS must be at least 1");
      end
      if (EXIT_TICKS < 1) begin : g_bad_exit
         $error("dpm_mode_fsm: EXIT_TICKS must be at least 1");
      end
   endgenerate

   pm_mode_e      mode_q, mode_d;
   logic [EW-1:0] ent_q, ent_d;
   logic [XW-1:0] ext_q, ext_d;

   always_comb begin
      mode_d = mode_q;
      ent_d  = ent_q;
      ext_d  = ext_q;
      if (mode_q == PM_ON) begin
         ext_d = '0;
         if (cond == PM_ON) begin
            ent_d = '0;
         end else if (tick) begin
            if (ent_q == EW'(ENTRY_TICKS - 1)) begin
               mode_d = cond;
               ent_d  = '0;
            end else begin
               ent_d = ent_q + 1'b1;
            end
         end
      end else begin
         ent_d = '0;
         if (cond == PM_ON) begin
            if (tick) begin
               if (ext_q == XW'(EXIT_TICKS - 1)) begin
                  mode_d = PM_ON;
                  ext_d  = '0;
               end else begin
                  ext_d = ext_q + 1'b1;
               end
            end
         end else begin
            ext_d = '0;
            if (cond != mode_q) mode_d = cond;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_ON;
         ent_q  <= '0;
         ext_q  <= '0;
      end else begin
         mode_q <= mode_d;
         ent_q  <= ent_d;
         ext_q  <= ext_d;
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/dpm_state_detector.sv
module dpm_state_detector
   import dpm_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV  = 27000,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned ACT_WIN_TICKS = 40,
   parameter int unsigned ENTRY_TICKS   = 5900,
   parameter int unsigned EXIT_TICKS    = 368
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   input  logic vsync_in,
   input  logic force_on,
   output logic lvl_stby_n,
   output logic lvl_susp_n,
   output logic lvl_off_n
);
   localparam int unsigned N_CH = 2;

   logic            tick;
   logic [N_CH-1:0] raw_sync;
   logic [N_CH-1:0] ch_active;
   pm_mode_e        cond_mode;
   pm_mode_e        mode_q;
   logic [2:0]      code;

   assign raw_sync = {vsync_in, hsync_in};

   dpm_tick_gen #(.DIV(PRESCALE_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_chan
         dpm_sync_activity #(
            .SYNC_STAGES   (SYNC_STAGES),
            .ACT_WIN_TICKS (ACT_WIN_TICKS)
         ) u_act (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .raw_in (raw_sync[c]),
            .active (ch_active[c])
         );
      end
   endgenerate

   assign cond_mode = pm_classify(ch_active[0], ch_active[1]);

   dpm_mode_fsm #(
      .ENTRY_TICKS (ENTRY_TICKS),
      .EXIT_TICKS  (EXIT_TICKS)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .cond  (cond_mode),
      .mode  (mode_q)
   );

   assign code = force_on ? 3'b111 : pm_encode(mode_q);
   assign lvl_stby_n = code[2];
   assign lvl_susp_n = code[1];
   assign lvl_off_n  = code[0];
endmodule

// File: rtl/dpm_state_detector_chk.sv
module dpm_state_detector_chk #(
   parameter int unsigned ENTRY_TICKS = 5900,
   parameter int unsigned EXIT_TICKS  = 368
) (
   input logic       clk,
   input logic       rst_n,
   input logic       force_on,
   input logic       tick,
   input logic [1:0] mode,
   input logic [1:0] cond,
   input logic       lvl_stby_n,
   input logic       lvl_susp_n,
   input logic       lvl_off_n
);
   localparam logic [1:0] M_ON = 2'd0;
   localparam int unsigned EW = $clog2(ENTRY_TICKS + 1);
   localparam int unsigned XW = $clog2(EXIT_TICKS + 1);

   logic [EW-1:0] ent_w;
   logic [XW-1:0] ext_w;
   logic [2:0]    outs;
   logic          entry_due, exit_due;

   assign outs = {lvl_stby_n, lvl_susp_n, lvl_off_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_w <= '0;
         ext_w <= '0;
      end else begin
         if (mode == M_ON && cond != M_ON) begin
            if (tick) ent_w <= ent_w + 1'b1;
         end else begin
            ent_w <= '0;
         end
         if (mode != M_ON && cond == M_ON) begin
            if (tick) ext_w <= ext_w + 1'b1;
         end else begin
            ext_w <= '0;
         end
      end
   end

   assign entry_due = tick && (ent_w == EW'(ENTRY_TICKS - 1));
   assign exit_due  = tick && (ext_w == XW'(EXIT_TICKS - 1));

   // R8: the override forces the ON code
   a_r8_override_on: assert property (@(posedge clk) disable iff (!rst_n)
      force_on |-> (outs == 3'b111));

   // R3: only the four thermometer codes appear
   a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      (outs == 3'b111) || (outs == 3'b011) || (outs == 3'b001) || (outs == 3'b000));

   // R4: ON is left only when the entry delay has run out
   a_r4_no_early_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ON && !(cond != M_ON && entry_due)) |=> (mode == M_ON));

   // R6: ON is regained only when the exit delay has run out
   a_r6_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != M_ON && !(cond == M_ON && exit_due)) |=> (mode != M_ON));

   // R7: a different saving condition is taken on the next clock
   a_r7_direct_move: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != M_ON && cond != M_ON && cond != mode) |=> (mode == $past(cond)));
endmodule

bind dpm_state_detector dpm_state_detector_chk #(
   .ENTRY_TICKS (ENTRY_TICKS),
   .EXIT_TICKS  (EXIT_TICKS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .force_on   (force_on),
   .tick       (tick),
   .mode       (mode_q),
   .cond       (cond_mode),
   .lvl_stby_n (lvl_stby_n),
   .lvl_susp_n (lvl_susp_n),
   .lvl_off_n  (lvl_off_n)
);

// File: tb/dpm_state_detector_tb_top.sv
module dpm_state_detector_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 4;
   localparam int WIN   = 6;
   localparam int ENTRY = 20;
   localparam int EXIT  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = 1'b0;
   logic vsync_in = 1'b0;
   logic force_on = 1'b0;
   logic lvl_stby_n, lvl_susp_n, lvl_off_n;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit h_en = 1'b0;
   bit v_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpm_state_detector #(
      .PRESCALE_DIV  (DIV),
      .SYNC_STAGES   (2),
      .ACT_WIN_TICKS (WIN),
      .ENTRY_TICKS   (ENTRY),
      .EXIT_TICKS    (EXIT)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_in   (hsync_in),
      .vsync_in   (vsync_in),
      .force_on   (force_on),
      .lvl_stby_n (lvl_stby_n),
      .lvl_susp_n (lvl_susp_n),
      .lvl_off_n  (lvl_off_n)
   );

   // Pulse generators: horizontal toggles every 2 clocks, vertical every 8.
   int h_ph = 0;
   int v_ph = 0;
   always @(negedge clk) begin
      h_ph = h_ph + 1;
      v_ph = v_ph + 1;
      if (h_en && (h_ph % 2 == 0)) hsync_in = ~hsync_in;
      if (v_en && (v_ph % 8 == 0)) vsync_in = ~vsync_in;
   end

   // Reference model. Modes: 0 on, 1 stand-by, 2 suspend, 3 off.
   int m_pc, m_hc, m_vc, m_mode, m_ent, m_ext;
   bit m_h1, m_h2, m_h3, m_v1, m_v2, m_v3;

   function automatic int classify(bit h, bit v);
      if (h && v) return 0;
      if (!h && v) return 1;
      if (h && !v) return 2;
      return 3;
   endfunction

   function automatic logic [2:0] code_of(int m);
      case (m)
         0: return 3'b111;
         1: return 3'b011;
         2: return 3'b001;
         default: return 3'b000;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc = 0; m_hc = WIN; m_vc = WIN; m_mode = 0; m_ent = 0; m_ext = 0;
         m_h1 = 0; m_h2 = 0; m_h3 = 0; m_v1 = 0; m_v2 = 0; m_v3 = 0;
      end else begin
         bit tk, he, ve;
         int cond;
         tk = (m_pc == DIV - 1);
         he = (m_h2 != m_h3);
         ve = (m_v2 != m_v3);
         cond = classify(m_hc < WIN, m_vc < WIN);
         if (m_mode == 0) begin
            m_ext = 0;
            if (cond == 0) m_ent = 0;
            else if (tk) begin
               m_ent = m_ent + 1;
               if (m_ent == ENTRY) begin m_mode = cond; m_ent = 0; end
            end
         end else begin
            m_ent = 0;
            if (cond == 0) begin
               if (tk) begin
                  m_ext = m_ext + 1;
                  if (m_ext == EXIT) begin m_mode = 0; m_ext = 0; end
               end
            end else begin
               m_ext = 0;
               m_mode = cond;
            end
         end
         if (he) m_hc = 0; else if (tk && m_hc < WIN) m_hc = m_hc + 1;
         if (ve) m_vc = 0; else if (tk && m_vc < WIN) m_vc = m_vc + 1;
         m_pc = tk ? 0 : m_pc + 1;
         m_h3 = m_h2; m_h2 = m_h1; m_h1 = hsync_in;
         m_v3 = m_v2; m_v2 = m_v1; m_v1 = vsync_in;
      end
   end

   task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model, a quarter period after the falling edge.
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n)
         check3({cur_req, " model"}, {lvl_stby_n, lvl_susp_n, lvl_off_n},
                force_on ? 3'b111 : code_of(m_mode));
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_now(string req, logic [2:0] exp);
      #(CLK_PERIOD/4);
      check3(req, {lvl_stby_n, lvl_susp_n, lvl_off_n}, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_clk(3);
      expect_now("R1", 3'b111);
      rst_n = 1'b1;
      wait_clk(1);
      expect_now("R1", 3'b111);

      // R2/R3: both lines pulsing, vertical slow -> steady ON
      cur_req = "R2";
      h_en = 1; v_en = 1;
      wait_clk(300);
      expect_now("R2", 3'b111);
      expect_now("R3", 3'b111);

      // R4: horizontal stops, ON held through the entry delay, then stand-by
      cur_req = "R4";
      h_en = 0;
      wait_clk(60);
      expect_now("R4", 3'b111);
      wait_clk(200);
      expect_now("R3", 3'b011);

      // R7: stand-by -> off -> suspend, each without entry delay
      cur_req = "R7";
      v_en = 0;
      wait_clk(60);
      expect_now("R7", 3'b000);
      h_en = 1;
      wait_clk(20);
      expect_now("R7", 3'b001);

      // R6: both pulsing again, exit delay then ON
      cur_req = "R6";
      v_en = 1;
      wait_clk(12);
      expect_now("R6", 3'b001);
      wait_clk(70);
      expect_now("R6", 3'b111);

      // R5: departure cancelled, second departure restarts the count
      cur_req = "R5";
      h_en = 0;
      wait_clk(70);
      expect_now("R5", 3'b111);
      h_en = 1;
      wait_clk(40);
      expect_now("R5", 3'b111);
      h_en = 0;
      wait_clk(80);
      expect_now("R5", 3'b111);
      wait_clk(150);
      expect_now("R5", 3'b011);

      // R8: override while off, then release
      cur_req = "R8";
      v_en = 0;
      wait_clk(60);
      expect_now("R8", 3'b000);
      wait_clk(1);
      force_on = 1'b1;
      expect_now("R8", 3'b111);
      wait_clk(100);
      expect_now("R8", 3'b111);
      wait_clk(1);
      force_on = 1'b0;
      expect_now("R8", 3'b000);
      wait_clk(10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule